// File: doc/BRIEF.md
# Disk Controller Command and Status Registers

This block is the programmer-visible register file of a head-per-track disk controller. It stores an 18-bit function/status word, a 21-bit disk word address (an 18-bit low half and a 3-bit high half) and an 18-bit data buffer. It decodes strobed I/O commands. Each command carries a 6-bit device code and a 3-bit operation field. The commands load, read, clear or toggle these registers, start a transfer and abort it. A separate transfer engine does the data movement and the rotational search. That engine reports a busy level, one-cycle error pulses and a one-cycle done pulse, and it takes the function, the address, the go strobe and the abort strobe from this block.

While the engine is busy, every state-changing or data-read command except the skip test and the reset is refused. The refused command sets a programming-error flag instead. Read commands still return their data. The status word is kept normalized: its error summary bit always reflects the hard error flags, and its unused middle bits always read as zero. The interrupt request and the skip condition are derived from it.

The command port is a plain strobe with no back-pressure. A command is taken on every clock edge where `cmd_stb` is high. Read data is combinational during the strobe cycle. State changes and the go/abort strobes appear after that edge.

Top module: `dkc_regfile`

## Requirements
- R1: `rst_n` low, or the reset command (main code 0o70, op 1), clears status, address and buffer. The reset command works even while busy, and it pulses `abort_o` for one cycle after its edge.
- R2: Status bits 6:3 always read 0. Bit 17 (error summary) is 1 exactly when any of bits 16:10 is 1. Bits 9 and 8 do not set it.
- R3: `irq_o` = bit 0 (interrupt enable) AND (bit 17 OR bit 7 done). `skip_o` = bit 17 OR bit 7.
- R4: The toggle command (main, op 3) XORs `acc_i[2:0]` into status bits 2:0, where bits 2:1 are the function and bit 0 is the enable. The clear-function command (main, op 2) zeroes bits 2:0.
- R5: Load-low (main, op 6) writes `acc_i[17:0]` to address bits 17:0 and keeps bits 20:18. Load-high (main, op 7) writes `acc_i[2:0]` to bits 20:18 and keeps the low half. Load-buffer (main, op 5) writes the buffer. Reads use aux code 0o72: op 0 buffer, op 1 low address, op 2 high address.
- R6: The high-address read returns bits 20:18 in `rd_data_o[2:0]` and status bit 10 (non-existent disk) in `rd_data_o[3]`. All other bits are 0.
- R7: While `busy_i` is high, any command except skip (main op 0), reset, and no-op codes changes no register. Instead it sets status bit 8 (programming error). Go does not pulse.
- R8: Reads while busy still return their data. The status read (aux, op 3) returns the word with bit 8 already set.
- R9: Go (main, op 4) pulses `go_o` for one cycle after its edge only if the function (bits 2:1) is non-zero and the engine is idle.
- R10: `evt_err_i[7:0]` pulses set status bits 16:9 (bit i to bit 9+i), and `evt_done_i` sets bit 7. These flags stay set until they are cleared. An event in the same cycle as a clear-status is kept.
- R11: Clear-status (aux, op 4) zeroes the whole status word, including function and enable.
- R12: A strobe whose device code is neither 0o70 nor 0o72, or an aux op 5 to 7, changes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command strobe |
| cmd_dev | input | 6 | Device code of the command |
| cmd_op | input | 3 | Operation field |
| acc_i | input | 18 | Accumulator operand |
| busy_i | input | 1 | Transfer engine busy |
| evt_err_i | input | 8 | Error pulses for status bits 16:9 |
| evt_done_i | input | 1 | Transfer done pulse |
| rd_data_o | output | 18 | Combinational read data |
| skip_o | output | 1 | Skip condition |
| irq_o | output | 1 | Interrupt request |
| go_o | output | 1 | Start-transfer strobe |
| abort_o | output | 1 | Cancel-transfer strobe |
| func_o | output | 2 | Current function |
| addr_o | output | 21 | Disk word address |

## Verification
The bench sweeps every pair of starting function/enable value and toggle operand. A design that loads the operand instead of XORing it gives wrong function values. It also drives all 256 error-pulse patterns. A summary computed over the wrong range would flag on data-channel timing, or miss a write-lock error. Busy-time commands are checked at the ports afterwards. A design that only flags the error, but still applies the load, would show a changed address or function. The high-address read is checked with and without the non-existent-disk flag, and a foreign device code is checked to be inert.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int STW = 18;
  localparam int B_SUM  = 17;
  localparam int B_NED  = 10;
  localparam int B_PGE  = 8;
  localparam int B_DONE = 7;
  localparam int B_IE   = 0;

  typedef enum logic [3:0] {
    C_NONE, C_SKIP, C_RESET, C_FCLR, C_FXOR, C_GO, C_LDBUF, C_LDLO, C_LDHI,
    C_RDBUF, C_RDLO, C_RDHI, C_RDSTA, C_CLRSTA
  } cmd_e;

  // commands refused (and flagged) while the engine is busy
  function automatic logic guarded(input cmd_e c);
    return !(c == C_NONE || c == C_SKIP || c == C_RESET);
  endfunction

  // normalize a raw status word: clear summary and spare bits, recompute summary
  function automatic logic [STW-1:0] norm(input logic [STW-1:0] raw);
    logic [STW-1:0] r;
    r = raw;
    r[B_SUM] = 1'b0;
    r[6:3] = 4'b0;
    r[B_SUM] = |r[16:10];
    return r;
  endfunction
endpackage

// File: rtl/dkc_decode.sv
module dkc_decode
  import dkc_pkg::*;
#(
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] DEV_MAIN = 6'o70,
  parameter logic [DEV_W-1:0] DEV_AUX  = 6'o72
) (
  input  logic             stb,
  input  logic [DEV_W-1:0] dev,
  input  logic [2:0]       op,
  output cmd_e             cmd
);
  always_comb begin
    cmd = C_NONE;
    if (stb && dev == DEV_MAIN) begin
      case (op)
        3'd0: cmd = C_SKIP;
        3'd1: cmd = C_RESET;
        3'd2: cmd = C_FCLR;
        3'd3: cmd = C_FXOR;
        3'd4: cmd = C_GO;
        3'd5: cmd = C_LDBUF;
        3'd6: cmd = C_LDLO;
        default: cmd = C_LDHI;
      endcase
    end else if (stb && dev == DEV_AUX) begin
      case (op)
        3'd0: cmd = C_RDBUF;
        3'd1: cmd = C_RDLO;
        3'd2: cmd = C_RDHI;
        3'd3: cmd = C_RDSTA;
        3'd4: cmd = C_CLRSTA;
        default: cmd = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/dkc_status.sv
module dkc_status
  import dkc_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  cmd_e           cmd_i,
  input  logic [2:0]     acc_i,
  input  logic           busy_i,
  input  logic [7:0]     evt_err_i,
  input  logic           evt_done_i,
  output logic [STW-1:0] sta_q,
  output logic           go_q,
  output logic           abort_q
);
  logic [STW-1:0] raw, sta_d;
  logic go_d, abort_d;

  always_comb begin
    raw = sta_q;
    go_d = 1'b0;
    abort_d = 1'b0;
    if (cmd_i == C_RESET) begin
      raw = '0;
      abort_d = 1'b1;
    end else begin
      if (busy_i && guarded(cmd_i)) begin
        raw[B_PGE] = 1'b1;
      end else begin
        case (cmd_i)
          C_FCLR:   raw[2:0] = 3'b0;
          C_FXOR:   raw[2:0] = raw[2:0] ^ acc_i;
          C_CLRSTA: raw = '0;
          C_GO:     go_d = (raw[2:1] != 2'b0);
          default:  ;
        endcase
      end
      raw[16:9] = raw[16:9] | evt_err_i;
      if (evt_done_i) raw[B_DONE] = 1'b1;
    end
    sta_d = norm(raw);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_q <= '0;
      go_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      sta_q <= sta_d;
      go_q <= go_d;
      abort_q <= abort_d;
    end
  end

  AST_BUSY_SETS_PGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && guarded(cmd_i) |=> sta_q[B_PGE]); // R7
  AST_BUSY_FUNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && cmd_i != C_RESET |=> $stable(sta_q[2:0])); // R7
  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |-> sta_q == '0); // R1
  AST_GO_NEEDS_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> $past(sta_q[2:1] != 2'b0 && !busy_i)); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sta_q[B_DONE] && cmd_i != C_RESET && cmd_i != C_CLRSTA |=> sta_q[B_DONE]); // R10
endmodule

// File: rtl/dkc_addrbuf.sv
module dkc_addrbuf
  import dkc_pkg::*;
#(
  parameter int HI_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cmd_e                cmd_i,
  input  logic                busy_i,
  input  logic [STW-1:0]      acc_i,
  output logic [STW+HI_W-1:0] addr_q,
  output logic [STW-1:0]      buf_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || cmd_i == C_RESET) begin
      addr_q <= '0;
      buf_q <= '0;
    end else if (!busy_i) begin
      case (cmd_i)
        C_LDLO:  addr_q[STW-1:0] <= acc_i;
        C_LDHI:  addr_q[STW+HI_W-1:STW] <= acc_i[HI_W-1:0];
        C_LDBUF: buf_q <= acc_i;
        default: ;
      endcase
    end
  end

  AST_ADDR_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i && cmd_i != C_RESET |=> $stable(addr_q) && $stable(buf_q)); // R7
endmodule

// File: rtl/dkc_regfile.sv
module dkc_regfile
  import dkc_pkg::*;
#(
  parameter int DEV_W = 6,
  parameter logic [DEV_W-1:0] DEV_MAIN = 6'o70,
  parameter logic [DEV_W-1:0] DEV_AUX  = 6'o72,
  parameter int HI_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_stb,
  input  logic [DEV_W-1:0]    cmd_dev,
  input  logic [2:0]          cmd_op,
  input  logic [STW-1:0]      acc_i,
  input  logic                busy_i,
  input  logic [7:0]          evt_err_i,
  input  logic                evt_done_i,
  output logic [STW-1:0]      rd_data_o,
  output logic                skip_o,
  output logic                irq_o,
  output logic                go_o,
  output logic                abort_o,
  output logic [1:0]          func_o,
  output logic [STW+HI_W-1:0] addr_o
);
  cmd_e cmd;
  logic [STW-1:0] sta, bufv, rd_sta, rd_hi;

  dkc_decode #(.DEV_W(DEV_W), .DEV_MAIN(DEV_MAIN), .DEV_AUX(DEV_AUX)) u_dec (
    .stb(cmd_stb), .dev(cmd_dev), .op(cmd_op), .cmd(cmd));

  dkc_status u_sta (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .acc_i(acc_i[2:0]), .busy_i(busy_i),
    .evt_err_i(evt_err_i), .evt_done_i(evt_done_i),
    .sta_q(sta), .go_q(go_o), .abort_q(abort_o));

  dkc_addrbuf #(.HI_W(HI_W)) u_ab (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .busy_i(busy_i), .acc_i(acc_i),
    .addr_q(addr_o), .buf_q(bufv));

  always_comb begin
    rd_sta = sta;
    if (busy_i) rd_sta[B_PGE] = 1'b1;
    rd_sta = norm(rd_sta);
    rd_hi = '0;
    rd_hi[HI_W-1:0] = addr_o[STW+HI_W-1:STW];
    rd_hi[HI_W] = sta[B_NED];
    case (cmd)
      C_RDBUF: rd_data_o = bufv;
      C_RDLO:  rd_data_o = addr_o[STW-1:0];
      C_RDHI:  rd_data_o = rd_hi;
      C_RDSTA: rd_data_o = rd_sta;
      default: rd_data_o = '0;
    endcase
  end

  assign skip_o = sta[B_SUM] | sta[B_DONE];
  assign irq_o  = sta[B_IE] & skip_o;
  assign func_o = sta[2:1];
endmodule

// File: tb/dkc_regfile_test.sv
module dkc_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_stb = 1'b0;
  logic [5:0] cmd_dev = '0;
  logic [2:0] cmd_op = '0;
  logic [17:0] acc_i = '0;
  logic busy_i = 1'b0;
  logic [7:0] evt_err_i = '0;
  logic evt_done_i = 1'b0;
  logic [17:0] rd_data_o;
  logic skip_o, irq_o, go_o, abort_o;
  logic [1:0] func_o;
  logic [20:0] addr_o;

  int total = 0, bad = 0;
  bit finished = 0;
  localparam logic [5:0] M = 6'o70, A = 6'o72;

  dkc_regfile uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic issue(input logic [5:0] d, input logic [2:0] o, input logic [17:0] a);
    @(negedge clk);
    cmd_stb = 1; cmd_dev = d; cmd_op = o; acc_i = a;
    @(negedge clk);
    cmd_stb = 0; acc_i = '0;
  endtask

  task automatic peek(input logic [5:0] d, input logic [2:0] o, output logic [17:0] v);
    @(negedge clk);
    cmd_stb = 1; cmd_dev = d; cmd_op = o;
    #1 v = rd_data_o;
    @(negedge clk);
    cmd_stb = 0;
  endtask

  task automatic pulse_evt(input logic [7:0] e, input logic dn);
    @(negedge clk);
    evt_err_i = e; evt_done_i = dn;
    @(negedge clk);
    evt_err_i = '0; evt_done_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [17:0] v;
    logic [17:0] e_sta;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(A, 3, v); chk("R1 status", v, 0);
    peek(A, 1, v); chk("R1 addr lo", v, 0);
    peek(A, 2, v); chk("R1 addr hi", v, 0);
    peek(A, 0, v); chk("R1 buffer", v, 0);
    chk("R1 irq/skip", {irq_o, skip_o}, 0);

    // R4 exhaustive toggle sweep
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 8; a++) begin
        issue(A, 4, 0);
        issue(M, 3, 18'(s));
        issue(M, 3, 18'(a) | 18'h3FFF8);
        peek(A, 3, v); chk("R4 xor", v, 32'(s ^ a));
      end
      issue(M, 2, 0);
      peek(A, 3, v); chk("R4 clear func", v, 0);
    end

    // R9 go per function
    for (int f = 0; f < 4; f++) begin
      issue(A, 4, 0);
      issue(M, 3, 18'(f << 1));
      issue(M, 4, 0);
      chk("R9 go", go_o, 32'(f != 0));
      @(negedge clk); chk("R9 go one cycle", go_o, 0);
    end

    // R2 / R10 exhaustive error sweep
    for (int e = 0; e < 256; e++) begin
      issue(A, 4, 0);
      pulse_evt(8'(e), 0);
      pulse_evt(0, 0);
      e_sta = (18'(e) << 9) | (((e >> 1) != 0) ? 18'h20000 : 18'h0);
      peek(A, 3, v); chk("R2 R10 err summary", v, e_sta);
    end
    // R10 event kept over a concurrent clear-status
    @(negedge clk);
    cmd_stb = 1; cmd_dev = A; cmd_op = 4; evt_done_i = 1;
    @(negedge clk);
    cmd_stb = 0; evt_done_i = 0;
    peek(A, 3, v); chk("R10 done vs clear", v, 18'h80);

    // R3 irq and skip combinations
    for (int k = 0; k < 8; k++) begin
      issue(A, 4, 0);
      if (k[0]) issue(M, 3, 1);
      pulse_evt(k[2] ? 8'h80 : 8'h0, k[1]);
      chk("R3 skip", skip_o, 32'(k[1] | k[2]));
      chk("R3 irq", irq_o, 32'(k[0] & (k[1] | k[2])));
    end
    // R2 data-channel timing alone does not raise summary or skip
    issue(A, 4, 0); issue(M, 3, 1); pulse_evt(8'h01, 0);
    chk("R2 bit9 no summary", {irq_o, skip_o}, 0);

    // R5 / R6 address and buffer
    issue(A, 4, 0);
    issue(M, 6, 18'h2AAAA);
    issue(M, 7, 18'h3FFFD);
    peek(A, 1, v); chk("R5 addr lo", v, 18'h2AAAA);
    peek(A, 2, v); chk("R6 addr hi", v, 5);
    chk("R5 addr port", addr_o, 21'h16AAAA);
    issue(M, 6, 18'h15555);
    peek(A, 2, v); chk("R5 hi kept", v, 5);
    issue(M, 7, 2);
    peek(A, 1, v); chk("R5 lo kept", v, 18'h15555);
    pulse_evt(8'h02, 0);
    peek(A, 2, v); chk("R6 hi with ned", v, 18'hA);
    issue(M, 5, 18'h12345);
    peek(A, 0, v); chk("R5 buffer", v, 18'h12345);

    // R7 busy interlock
    issue(A, 4, 0);
    issue(M, 3, 18'h2);
    @(negedge clk); busy_i = 1;
    issue(M, 6, 18'h00001); issue(M, 7, 7); issue(M, 5, 0);
    issue(M, 3, 7); issue(M, 2, 0); issue(A, 4, 0);
    issue(M, 4, 0); chk("R7 no go busy", go_o, 0);
    @(negedge clk); busy_i = 0;
    peek(A, 1, v); chk("R7 addr lo kept", v, 18'h15555);
    peek(A, 2, v); chk("R7 addr hi kept", v, 18'h2);
    peek(A, 0, v); chk("R7 buffer kept", v, 18'h12345);
    peek(A, 3, v); chk("R7 pge, func kept", v, 18'h102);

    // R8 reads while busy
    issue(A, 4, 0);
    @(negedge clk); busy_i = 1;
    peek(A, 0, v); chk("R8 buffer busy", v, 18'h12345);
    peek(A, 3, v); chk("R8 status busy", v, 18'h100);
    @(negedge clk); busy_i = 0;
    issue(A, 4, 0);
    @(negedge clk); busy_i = 1;
    peek(A, 1, v); chk("R8 addr busy", v, 18'h15555);
    @(negedge clk); busy_i = 0;
    peek(A, 3, v); chk("R8 pge after read", v, 18'h100);

    // R11 clear status
    issue(M, 3, 7); pulse_evt(8'h40, 1);
    issue(A, 4, 0);
    peek(A, 3, v); chk("R11 cleared", v, 0);

    // R12 foreign code and spare ops
    issue(M, 3, 5);
    issue(6'o55, 3, 7); issue(6'o55, 1, 0); issue(A, 5, 0); issue(A, 7, 0);
    peek(A, 3, v); chk("R12 status kept", v, 5);
    peek(6'o55, 0, v); chk("R12 read zero", v, 0);
    peek(A, 6, v); chk("R12 spare read zero", v, 0);

    // R1 reset command, also while busy
    pulse_evt(8'h80, 1);
    @(negedge clk); busy_i = 1;
    issue(M, 1, 0);
    chk("R1 abort pulse", abort_o, 1);
    @(negedge clk); busy_i = 0;
    chk("R1 abort one cycle", abort_o, 0);
    peek(A, 3, v); chk("R1 status cleared", v, 0);
    peek(A, 1, v); chk("R1 addr cleared", v, 0);
    peek(A, 0, v); chk("R1 buf cleared", v, 0);
    chk("R1 skip cleared", skip_o, 0);
    finish_run();
  end
endmodule